// File: doc/BRIEF.md
# Page Permission and Protection-Key Evaluator

This block turns the permission bits collected during a page-table walk into the final access rights for one translation. It takes the user, writable and no-execute bits of every walk level together with the leaf's protection key and dirty state. It also takes the privilege of the access, the kind of access and a set of paging control flags. From these it works out a read/write/execute grant mask and decides whether the requested access faults. When it faults, a separate flag says whether the cause was a protection key.

A walker drives the inputs once it has the leaf entry. The block evaluates them in one pass and registers the result, so the answer appears on the outputs one clock later. A new evaluation can start on every cycle. The block has no memory of earlier requests. It does not read or walk tables and does not update accessed or dirty bits.

Top module: `perm_eval`

## Requirements
- R1: While `rst_n` is low at a rising edge, `grant`, `fault` and `key_fault` are cleared to zero. In every other cycle, the outputs show the evaluation of the inputs sampled at the previous rising edge.
- R2: Level bits are merged as follows: effective user and effective writable are the AND over all `LEVELS` entries, and effective no-execute is the OR over all entries. When `nx_en` is 0, every no-execute bit is ignored.
- R3: A user access (`priv_mode` = 0) to a page whose effective user bit is 0 raises `fault` with `key_fault` = 0, whatever the access kind and key state.
- R4: `grant` bit 0 is read, bit 1 is write and bit 2 is execute. In mode 2 (supervisor with user-access blocking), a user page gets neither read nor write. In every other case read is given, and write is given when the effective writable bit is 1 or when the access is not a user access and `wp_en` is 0. Modes 1 and 3 are both plain supervisor.
- R5: Execute is given when effective no-execute is 0, and in addition either the access is a user access or the combination of `exec_prev_en` = 1 with a user page does not hold.
- R6: The key register used is chosen as follows. For a user page it is `ukey_reg` when `ukey_en` = 1. For a supervisor page it is `skey_reg` when `skey_en` = 1. In every other case an all-zero value is used, and all-zero means no key restriction.
- R7: For leaf key k, register bit 2k set removes read and write. Bit 2k+1 set, with bit 2k clear, removes write only when the access is a user access or `wp_en` = 1. Execute is never removed by a key.
- R8: `acc_type` 0 is load, 1 is store, 2 is fetch, and 3 is treated as fetch. The requested access uses the `grant` bit at that index. If the key-limited rights deny it, `fault` and `key_fault` are both 1. This cause takes precedence over a page-rights denial but not over R3.
- R9: Otherwise the final rights are the page rights ANDed with the key-limited rights. If these deny the requested access, `fault` = 1 and `key_fault` = 0.
- R10: When there is no fault and `leaf_dirty` = 0, write is cleared from `grant` unless the access is a store.
- R11: Whenever `fault` is 1, `grant` is all zero. `key_fault` is never 1 without `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_user | input | LEVELS | User-accessible bit of each walk level |
| lvl_write | input | LEVELS | Writable bit of each walk level |
| lvl_nx | input | LEVELS | No-execute bit of each walk level |
| leaf_key | input | KEY_W | Protection key of the leaf entry |
| leaf_dirty | input | 1 | Leaf entry already marked dirty |
| priv_mode | input | 2 | 0 user, 1 supervisor, 2 supervisor with user-access blocking, 3 supervisor |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 fetch |
| wp_en | input | 1 | Supervisor write protection enable |
| nx_en | input | 1 | No-execute bits honoured |
| exec_prev_en | input | 1 | Supervisor may not execute user pages |
| ukey_en | input | 1 | Key checks for user pages enabled |
| skey_en | input | 1 | Key checks for supervisor pages enabled |
| ukey_reg | input | 2*2^KEY_W | Key rights register for user pages |
| skey_reg | input | 2*2^KEY_W | Key rights register for supervisor pages |
| grant | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| fault | output | 1 | Requested access denied |
| key_fault | output | 1 | Denial caused by a protection key |

## Verification
The block has no internal state apart from its output register, so a wrong internal value can only show up on the outputs one cycle after the inputs that produced it. A bad merge of the levels, a wrong key-register choice or a misplaced mask bit shows up as a wrong `grant` bit or a wrong fault cause on that same result, with no delayed effect. The stimulus therefore pairs each input vector with the result on the next cycle. It covers all privilege modes, access kinds and flag combinations, with key registers and level bits weighted toward the denial corners.

// File: rtl/perm_pkg.sv
// Shared encodings for the permission evaluator.
// Assumes the grant mask bit order matches the access-kind code so a
// requested access is one indexed bit of the mask.
package perm_pkg;

    typedef enum logic [1:0] {
        MODE_USER    = 2'd0,
        MODE_SUP     = 2'd1,
        MODE_SUP_BLK = 2'd2,
        MODE_SUP_ALT = 2'd3
    } priv_mode_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_t;

    localparam int RD_BIT = 0;
    localparam int WR_BIT = 1;
    localparam int EX_BIT = 2;

    typedef logic [2:0] rights_t;

endpackage

// File: rtl/level_merge.sv
// Merges per-level permission bits into effective page attributes.
// Assumes bit g of each vector belongs to walk level g; order is irrelevant.
module level_merge #(
    parameter int LEVELS = 4
) (
    input  logic [LEVELS-1:0] user_bits,
    input  logic [LEVELS-1:0] write_bits,
    input  logic [LEVELS-1:0] nx_bits,
    input  logic              nx_honour,
    output logic              eff_user,
    output logic              eff_write,
    output logic              eff_nx
);
    logic [LEVELS:0] user_chain;
    logic [LEVELS:0] write_chain;
    logic [LEVELS:0] exec_chain;

    assign user_chain[0]  = 1'b1;
    assign write_chain[0] = 1'b1;
    assign exec_chain[0]  = 1'b1;

    // One AND stage per level; no-execute is inverted into an allow chain.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign user_chain[g+1]  = user_chain[g]  & user_bits[g];
        assign write_chain[g+1] = write_chain[g] & write_bits[g];
        assign exec_chain[g+1]  = exec_chain[g]  & ~nx_bits[g];
    end

    assign eff_user  = user_chain[LEVELS];
    assign eff_write = write_chain[LEVELS];
    assign eff_nx    = nx_honour & ~exec_chain[LEVELS];

endmodule

// File: rtl/page_rights.sv
// Derives read/write/execute rights from merged page attributes and mode.
// Assumes priv is already decoded; no key or dirty handling here.
module page_rights
    import perm_pkg::*;
(
    input  logic       eff_user,
    input  logic       eff_write,
    input  logic       eff_nx,
    input  priv_mode_t priv,
    input  logic       wp_on,
    input  logic       exec_guard,
    output rights_t    rights
);
    logic is_user;
    logic blocked;

    assign is_user = (priv == MODE_USER);
    assign blocked = (priv == MODE_SUP_BLK) && eff_user;

    // Combine mode, write protection and execute guard into a mask.
    always_comb begin
        rights         = '0;
        rights[RD_BIT] = !blocked;
        rights[WR_BIT] = !blocked && (eff_write || (!is_user && !wp_on));
        rights[EX_BIT] = !eff_nx && (is_user || !(exec_guard && eff_user));
    end

endmodule

// File: rtl/key_rights.sv
// Selects the key register by page ownership and derives key-limited rights.
// Assumes each key owns two adjacent register bits: access-off then write-off.
module key_rights
    import perm_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int NKEYS  = 1 << KEY_W,
    localparam int KREG_W = 2 * NKEYS
) (
    input  logic              eff_user,
    input  logic              is_user,
    input  logic              wp_on,
    input  logic [KEY_W-1:0]  key,
    input  logic              ukey_on,
    input  logic              skey_on,
    input  logic [KREG_W-1:0] ukey_word,
    input  logic [KREG_W-1:0] skey_word,
    output rights_t           kmask
);
    logic [KREG_W-1:0] sel_word;
    logic [KEY_W:0]    pair_idx;
    logic              acc_off;
    logic              wr_off;

    // Pick the register that governs this page, or none.
    always_comb begin
        if (eff_user) begin
            sel_word = ukey_on ? ukey_word : '0;
        end else begin
            sel_word = skey_on ? skey_word : '0;
        end
    end

    assign pair_idx = {key, 1'b0};
    assign acc_off  = sel_word[pair_idx];
    assign wr_off   = sel_word[pair_idx + 1'b1];

    // Apply the two disable bits of the selected key.
    always_comb begin
        kmask = 3'b111;
        if (acc_off) begin
            kmask[RD_BIT] = 1'b0;
            kmask[WR_BIT] = 1'b0;
        end else if (wr_off && (is_user || wp_on)) begin
            kmask[WR_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/perm_eval.sv
// Top of the permission evaluator: merges walk bits, applies page and key
// rights, checks the requested access and registers the result.
// Assumes inputs are stable around each rising edge; one result per cycle.
module perm_eval
    import perm_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int KEY_W  = 4,
    localparam int NKEYS  = 1 << KEY_W,
    localparam int KREG_W = 2 * NKEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] lvl_user,
    input  logic [LEVELS-1:0] lvl_write,
    input  logic [LEVELS-1:0] lvl_nx,
    input  logic [KEY_W-1:0]  leaf_key,
    input  logic              leaf_dirty,
    input  logic [1:0]        priv_mode,
    input  logic [1:0]        acc_type,
    input  logic              wp_en,
    input  logic              nx_en,
    input  logic              exec_prev_en,
    input  logic              ukey_en,
    input  logic              skey_en,
    input  logic [KREG_W-1:0] ukey_reg,
    input  logic [KREG_W-1:0] skey_reg,
    output logic [2:0]        grant,
    output logic              fault,
    output logic              key_fault
);
    priv_mode_t priv;
    acc_kind_t  acc;
    logic       is_user;
    logic       eff_user;
    logic       eff_write;
    logic       eff_nx;
    rights_t    pg_rights;
    rights_t    k_rights;
    rights_t    final_rights;
    rights_t    req_mask;
    logic       user_flt;
    logic       key_deny;
    logic       page_deny;
    logic       fault_d;
    logic       key_fault_d;
    rights_t    grant_d;

    assign priv    = priv_mode_t'(priv_mode);
    assign acc     = (acc_type == ACC_ALT) ? ACC_FETCH : acc_kind_t'(acc_type);
    assign is_user = (priv == MODE_USER);

    level_merge #(.LEVELS(LEVELS)) u_merge (
        .user_bits  (lvl_user),
        .write_bits (lvl_write),
        .nx_bits    (lvl_nx),
        .nx_honour  (nx_en),
        .eff_user   (eff_user),
        .eff_write  (eff_write),
        .eff_nx     (eff_nx)
    );

    page_rights u_page (
        .eff_user   (eff_user),
        .eff_write  (eff_write),
        .eff_nx     (eff_nx),
        .priv       (priv),
        .wp_on      (wp_en),
        .exec_guard (exec_prev_en),
        .rights     (pg_rights)
    );

    key_rights #(.KEY_W(KEY_W)) u_key (
        .eff_user  (eff_user),
        .is_user   (is_user),
        .wp_on     (wp_en),
        .key       (leaf_key),
        .ukey_on   (ukey_en),
        .skey_on   (skey_en),
        .ukey_word (ukey_reg),
        .skey_word (skey_reg),
        .kmask     (k_rights)
    );

    // Decide the fault cause in priority order and form the returned mask.
    always_comb begin
        req_mask     = rights_t'(3'b001 << acc);
        final_rights = pg_rights & k_rights;
        user_flt     = is_user && !eff_user;
        key_deny     = ~|(k_rights & req_mask);
        page_deny    = ~|(final_rights & req_mask);
        fault_d      = user_flt || key_deny || page_deny;
        key_fault_d  = !user_flt && key_deny;
        grant_d      = final_rights;
        if (!leaf_dirty && acc != ACC_STORE) begin
            grant_d[WR_BIT] = 1'b0;
        end
        if (fault_d) begin
            grant_d = '0;
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant     <= '0;
            fault     <= 1'b0;
            key_fault <= 1'b0;
        end else begin
            grant     <= grant_d;
            fault     <= fault_d;
            key_fault <= key_fault_d;
        end
    end

endmodule

// File: rtl/perm_eval_chk.sv
// Property checker for perm_eval, attached by bind; observes ports only.
// Assumes one result per cycle, one cycle after the inputs.
module perm_eval_chk #(
    parameter int LEVELS = 4,
    parameter int KREG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS-1:0] lvl_user,
    input logic              leaf_dirty,
    input logic [1:0]        priv_mode,
    input logic [1:0]        acc_type,
    input logic [2:0]        grant,
    input logic              fault,
    input logic              key_fault
);
    logic armed;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (grant == 3'b000 && !fault && !key_fault));

    // R11
    key_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_fault |-> fault);

    // R11
    fault_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> grant == 3'b000);

    // R3
    user_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(priv_mode) == 2'd0 && !(&$past(lvl_user)))
        |-> (fault && !key_fault));

    // R8
    granted_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !fault && $past(acc_type) != 2'd3) |-> grant[$past(acc_type)]);

    // R10
    clean_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(leaf_dirty) && $past(acc_type) != 2'd1) |-> !grant[1]);

endmodule

bind perm_eval perm_eval_chk #(.LEVELS(LEVELS), .KREG_W(KREG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_user   (lvl_user),
    .leaf_dirty (leaf_dirty),
    .priv_mode  (priv_mode),
    .acc_type   (acc_type),
    .grant      (grant),
    .fault      (fault),
    .key_fault  (key_fault)
);

// File: tb/sim_perm_eval.sv
// Bench for perm_eval: directed corners plus seeded random vectors,
// each compared with a bench model written from the requirements.
module sim_perm_eval;
    localparam int CLK_PERIOD = 10;
    localparam int LV = 4;
    localparam int KW = 4;
    localparam int KR = 2 * (1 << KW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LV-1:0] lvl_user = '0;
    logic [LV-1:0] lvl_write = '0;
    logic [LV-1:0] lvl_nx = '0;
    logic [KW-1:0] leaf_key = '0;
    logic          leaf_dirty = 1'b0;
    logic [1:0]    priv_mode = '0;
    logic [1:0]    acc_type = '0;
    logic          wp_en = 1'b0;
    logic          nx_en = 1'b0;
    logic          exec_prev_en = 1'b0;
    logic          ukey_en = 1'b0;
    logic          skey_en = 1'b0;
    logic [KR-1:0] ukey_reg = '0;
    logic [KR-1:0] skey_reg = '0;
    logic [2:0]    grant;
    logic          fault;
    logic          key_fault;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_eval #(.LEVELS(LV), .KEY_W(KW)) u0 (
        .clk(clk), .rst_n(rst_n), .lvl_user(lvl_user), .lvl_write(lvl_write),
        .lvl_nx(lvl_nx), .leaf_key(leaf_key), .leaf_dirty(leaf_dirty),
        .priv_mode(priv_mode), .acc_type(acc_type), .wp_en(wp_en), .nx_en(nx_en),
        .exec_prev_en(exec_prev_en), .ukey_en(ukey_en), .skey_en(skey_en),
        .ukey_reg(ukey_reg), .skey_reg(skey_reg), .grant(grant), .fault(fault),
        .key_fault(key_fault)
    );

    // Expected {key_fault, fault, grant} plus tag of the deciding rule.
    function automatic logic [4:0] model(output string tag);
        logic u, w, x, usr, ad, wd;
        logic [2:0] pg, km, fin, rq;
        logic [KR-1:0] kr;
        int a;
        u = &lvl_user;
        w = &lvl_write;
        x = nx_en && (|lvl_nx);
        usr = (priv_mode == 2'd0);
        a = (acc_type == 2'd3) ? 2 : int'(acc_type);
        rq = 3'b001 << a;
        pg = 3'b000;
        if (!(priv_mode == 2'd2 && u)) begin
            pg[0] = 1'b1;
            pg[1] = w || (!usr && !wp_en);
        end
        pg[2] = !x && (usr || !(exec_prev_en && u));
        if (u) kr = ukey_en ? ukey_reg : '0;
        else   kr = skey_en ? skey_reg : '0;
        ad = kr[2*leaf_key];
        wd = kr[2*leaf_key+1];
        km = 3'b111;
        if (ad) km[1:0] = 2'b00;
        else if (wd && (usr || wp_en)) km[1] = 1'b0;
        fin = pg & km;
        if (usr && !u) begin
            tag = "R3"; return {1'b0, 1'b1, 3'b000};
        end
        if ((km & rq) == 0) begin
            tag = "R8"; return {1'b1, 1'b1, 3'b000};
        end
        if ((fin & rq) == 0) begin
            tag = "R9"; return {1'b0, 1'b1, 3'b000};
        end
        if (!leaf_dirty && a != 1) begin
            fin[1] = 1'b0; tag = "R10";
        end else begin
            tag = "R4";
        end
        return {1'b0, 1'b0, fin};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {key_fault, fault, grant};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got kf=%b f=%b g=%b expected kf=%b f=%b g=%b",
                     req, act[4], act[3], act[2:0], exp[4], exp[3], exp[2:0]);
        end
    endtask

    // Apply the current inputs, wait for the registered result, compare.
    task automatic run(input string req);
        logic [4:0] exp;
        string tag;
        exp = model(tag);
        @(posedge clk);
        @(negedge clk);
        check((req == "") ? tag : req, exp);
    endtask

    task automatic base();
        lvl_user = '1; lvl_write = '1; lvl_nx = '0; leaf_key = '0;
        leaf_dirty = 1'b1; priv_mode = 2'd1; acc_type = 2'd0; wp_en = 1'b0;
        nx_en = 1'b1; exec_prev_en = 1'b0; ukey_en = 1'b0; skey_en = 1'b0;
        ukey_reg = '0; skey_reg = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        base();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 5'b0);
        rst_n = 1'b1;

        // R2: one non-writable level removes write for user store
        base(); priv_mode = 2'd0; lvl_write = 4'b1101; acc_type = 2'd1; run("R2");
        // R2: nx on one level blocks fetch; nx_en off ignores it
        base(); lvl_nx = 4'b0100; acc_type = 2'd2; run("R2");
        nx_en = 1'b0; run("R2");
        // R3: user access to supervisor page, each access kind
        for (int k = 0; k < 3; k++) begin
            base(); priv_mode = 2'd0; lvl_user = 4'b1011; acc_type = 2'(k); run("R3");
        end
        // R4: blocked supervisor reading a user page
        base(); priv_mode = 2'd2; run("R4");
        // R4: supervisor write to read-only page, wp off then on
        base(); lvl_write = 4'b0111; acc_type = 2'd1; run("R4");
        wp_en = 1'b1; run("R4");
        // R5: execute guard against user page for supervisor fetch
        base(); exec_prev_en = 1'b1; acc_type = 2'd2; run("R5");
        priv_mode = 2'd0; run("R5");
        // R6: supervisor page uses skey, user page with ukey disabled is free
        base(); skey_en = 1'b1; lvl_user = 4'b1110; skey_reg[0] = 1'b1; run("R6");
        base(); skey_en = 1'b1; skey_reg = '1; run("R6");
        // R7: write-disable only for supervisor when wp is on
        base(); ukey_en = 1'b1; leaf_key = 4'd15; ukey_reg[31] = 1'b1;
        acc_type = 2'd1; run("R7");
        wp_en = 1'b1; run("R7");
        acc_type = 2'd2; ukey_reg[30] = 1'b1; run("R7");
        // R8: key denial wins over page denial; access kind 3 acts as fetch
        base(); priv_mode = 2'd2; ukey_en = 1'b1; leaf_key = 4'd3;
        ukey_reg[6] = 1'b1; run("R8");
        base(); acc_type = 2'd3; lvl_nx = 4'b0001; run("R8");
        // R10: clean leaf, load vs store
        base(); leaf_dirty = 1'b0; run("R10");
        acc_type = 2'd1; run("R10");
        // R11: fault leaves no grant
        base(); priv_mode = 2'd0; lvl_user = '0; run("R11");

        for (int n = 0; n < 3000; n++) begin
            lvl_user     = (($urandom % 4) == 0) ? LV'($urandom) : '1;
            lvl_write    = (($urandom % 3) == 0) ? LV'($urandom) : '1;
            lvl_nx       = (($urandom % 3) == 0) ? LV'($urandom) : '0;
            leaf_key     = KW'($urandom);
            leaf_dirty   = 1'($urandom);
            priv_mode    = 2'($urandom);
            acc_type     = 2'($urandom);
            wp_en        = 1'($urandom);
            nx_en        = 1'($urandom);
            exec_prev_en = 1'($urandom);
            ukey_en      = 1'($urandom);
            skey_en      = 1'($urandom);
            ukey_reg     = (($urandom % 2) == 0) ? KR'($urandom) : '0;
            skey_reg     = (($urandom % 2) == 0) ? KR'($urandom) : '0;
            run("");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule